// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Target

This block is a 256-byte serial EEPROM target for a two-wire bus whose clock and data lines are toggled by software rather than by a dedicated controller. Both lines are sampled on the system clock. Each sample is compared with the previous one to find clock edges and the start and stop conditions. A transaction opens with a start, carries an 8-bit control byte whose least significant bit selects read or write, then an 8-bit word address. Each byte is acknowledged by pulling the data line low for one bus clock.

One tick counter runs through both the control and the address phase. When the address phase ends, the data register is reloaded from the memory at the assembled address. Under a read control byte, the data register is shifted out MSB first while the address bits are being clocked in, so a read returns the byte that an earlier transaction loaded. The memory contents come from a formula evaluated at reset.

Top module: `eep_bitbang_slave`

## Requirements
- R1: The data output is 0 whenever the block drives the line low; otherwise it equals the master's `sda_in` level (open-drain behaviour).
- R2: After reset and until a start condition is seen, rising clock edges are ignored and the block never drives the line.
- R3: A falling data line while the clock stays high is a start: the command byte clears and bit counting restarts from the first control bit, even in the middle of a transfer.
- R4: A rising data line while the clock stays high (stop) changes neither the bit count nor any register.
- R5: A bit is taken only on a rising clock sample whose data level equals the previous data sample; a data change in the same sample as the clock rise is ignored and not counted.
- R6: The control byte is 8 bits shifted in MSB first. Its bit 0 is the read flag (1 = read), and after its 8th bit an acknowledge becomes pending.
- R7: With an acknowledge pending, the next rising clock drives the line low for that bit and shifts no data; the drive is released at the following falling clock edge.
- R8: The word address is the next 8 bits, MSB first. After its last bit the data register is loaded with the memory byte at that address, an acknowledge becomes pending, and after that acknowledge the block is idle again.
- R9: During the address phase of a read, each rising clock drives the current MSB of the data register (a 1 releases the line) and shifts the register left; during a write the line is released.
- R10: The memory byte at address a is (5*a + INIT_SEED) mod 256, with INIT_SEED = 0x3C by default, and is loaded at reset.
- R11: Both inputs pass through a two-stage synchronizer; reset returns the block to idle with no acknowledge pending and no drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock level set by the master |
| sda_in | input | 1 | Bus data level set by the master |
| sda_out | output | 1 | Resolved data line: 0 when the block pulls low, else `sda_in` |

## Verification
The checker watches the output drive on every cycle. The line reads low whenever the block drives it. A drive can only begin right after a high clock sample, it ends one cycle after the synchronized clock falls, and it never persists through a clock that stays low. Bit counting, the restart and stop handling, the discarding of a coincident data change, the address assembly and the memory reload can only be shown by the bench's directed transactions. The bench checks them by where the acknowledge lands and by the read data bit patterns seen at the output.

// File: rtl/eep_pkg.sv
package eep_pkg;

    // Events derived from one synchronized sample pair versus the previous one
    typedef struct packed {
        logic rise;   // clock low -> high
        logic fall;   // clock high -> low
        logic cond;   // clock held high while data changed
        logic start;  // cond with data falling
        logic same;   // data level equals previous sample
        logic lvl;    // current data level
    } bus_evt_t;

    // Preload formula for the memory, truncated by the caller
    function automatic int unsigned rom_word(input int unsigned a,
                                             input int unsigned seed);
        return (5 * a) + seed;
    endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '1;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/eep_edge.sv
module eep_edge
    import eep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.rise  = scl_s & ~scl_q;
        evt.fall  = ~scl_s & scl_q;
        evt.cond  = scl_s & scl_q & (sda_s ^ sda_q);
        evt.start = evt.cond & ~sda_s;
        evt.same  = (sda_s == sda_q);
        evt.lvl   = sda_s;
    end
endmodule

// File: rtl/eep_rom.sv
module eep_rom
    import eep_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter int unsigned INIT_SEED = 32'h3C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= DATA_W'(rom_word(i, INIT_SEED));
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eep_core.sv
module eep_core
    import eep_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              drv_low
);
    localparam int CMD_END  = DATA_W + 1;
    localparam int ADDR_END = DATA_W + ADDR_W + 1;
    localparam int TICK_W   = $clog2(ADDR_END + 1);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [DATA_W-1:0] cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              ack;
        logic              drv;
    } core_t;

    core_t r, n;

    // Address as it will stand after shifting in the current bit
    assign rd_addr = {r.addr[ADDR_W-2:0], evt.lvl};

    always_comb begin
        n = r;
        if (evt.fall) n.drv = 1'b0;
        if (evt.cond) begin
            if (evt.start) begin
                n.tick = TICK_W'(1);
                n.cmd  = '0;
            end
        end else if (r.tick == '0 && !r.ack) begin
            // idle: wait for a start
        end else if (evt.rise) begin
            if (r.ack) begin
                n.drv = 1'b1;
                n.ack = 1'b0;
            end else if (evt.same) begin
                if (r.tick < TICK_W'(CMD_END)) begin
                    n.cmd  = {r.cmd[DATA_W-2:0], evt.lvl};
                    n.tick = r.tick + TICK_W'(1);
                    if (r.tick == TICK_W'(CMD_END - 1)) n.ack = 1'b1;
                end else if (r.tick < TICK_W'(ADDR_END)) begin
                    n.drv  = r.cmd[0] & ~r.data[DATA_W-1];
                    n.addr = rd_addr;
                    n.data = {r.data[DATA_W-2:0], 1'b0};
                    n.tick = r.tick + TICK_W'(1);
                    if (r.tick == TICK_W'(ADDR_END - 1)) begin
                        n.data = rd_data;
                        n.ack  = 1'b1;
                        n.tick = '0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= n;
    end

    assign drv_low = r.drv;
endmodule

// File: rtl/eep_bitbang_slave.sv
module eep_bitbang_slave
    import eep_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter int unsigned INIT_SEED   = 32'h3C
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_out
);
    logic [1:0]        sync_q;
    logic              scl_s;
    logic              sda_s;
    bus_evt_t          evt;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata;
    logic              drv_low;

    eep_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(sync_q)
    );
    assign scl_s = sync_q[1];
    assign sda_s = sync_q[0];

    eep_edge u_edge (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .evt(evt)
    );

    eep_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_SEED(INIT_SEED)) u_rom (
        .clk(clk), .rst(rst), .rd_addr(mem_addr), .rd_data(mem_rdata)
    );

    eep_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk(clk), .rst(rst), .evt(evt), .rd_data(mem_rdata),
        .rd_addr(mem_addr), .drv_low(drv_low)
    );

    assign sda_out = sda_in & ~drv_low;
endmodule

// File: rtl/eep_bitbang_chk.sv
module eep_bitbang_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic sda_out,
    input logic drv_low
);
    // R1
    drive_low_chk: assert property (@(posedge clk) disable iff (rst)
        drv_low |-> !sda_out);

    // R7
    drive_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_low) |-> $past(scl_s));

    // R7
    release_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_s) |=> !drv_low);

    // R7
    low_clock_chk: assert property (@(posedge clk) disable iff (rst)
        (!scl_s && !$past(scl_s) && !$past(scl_s, 2)) |-> !drv_low);
endmodule

bind eep_bitbang_slave eep_bitbang_chk u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_out(sda_out), .drv_low(drv_low)
);

// File: tb/tb_eep_bitbang_slave.sv
module tb_eep_bitbang_slave;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic sda_out;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    eep_bitbang_slave dut (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .sda_out(sda_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rom_val(input int a);
        return 8'((5 * a + 'h3C) % 256);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_bus(input logic c, input logic d);
        @(negedge clk);
        scl_in = c;
        sda_in = d;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        set_bus(1'b0, b);
        set_bus(1'b1, b);
        seen = sda_out;
        set_bus(1'b0, b);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic [7:0] seen);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(b[i], s);
            seen[i] = s;
        end
    endtask

    task automatic do_start();
        set_bus(1'b0, 1'b1);
        set_bus(1'b1, 1'b1);
        set_bus(1'b1, 1'b0);
        set_bus(1'b0, 1'b0);
    endtask

    task automatic ack_clock(input string req);
        logic s;
        clk_bit(1'b1, s);
        chk(req, s, 0);
    endtask

    task automatic t_reset();
        chk("R11 reset idle level", sda_out, 1);
        set_bus(1'b0, 1'b0);
        chk("R1 follows master low", sda_out, 0);
        set_bus(1'b0, 1'b1);
        chk("R1 follows master high", sda_out, 1);
    endtask

    task automatic t_idle();
        logic [7:0] seen;
        logic s;
        send_byte(8'hFF, seen);
        clk_bit(1'b1, s);
        chk("R2 idle bits ignored", seen, 8'hFF);
        chk("R2 no ack while idle", s, 1);
    endtask

    task automatic t_write();
        logic [7:0] seen;
        logic s;
        do_start();
        send_byte(8'hA0, seen);
        chk("R6 command phase released", seen, 8'hA0);
        ack_clock("R6 ack after command");
        chk("R7 release after ack", sda_out, 1);
        send_byte(8'h12, seen);
        chk("R9 write releases in address phase", seen, 8'h12);
        ack_clock("R8 ack after address");
        clk_bit(1'b1, s);
        chk("R8 idle after address ack", s, 1);
    endtask

    task automatic t_read(input logic [7:0] exp, input string req);
        logic [7:0] seen;
        do_start();
        send_byte(8'hA1, seen);
        ack_clock("R6 ack after read command");
        send_byte(8'hFF, seen);
        chk(req, seen, exp);
        ack_clock("R8 ack after read address");
    endtask

    task automatic t_restart();
        logic [7:0] seen;
        logic s;
        do_start();
        clk_bit(1'b1, s);
        clk_bit(1'b0, s);
        clk_bit(1'b1, s);
        set_bus(1'b0, 1'b1);
        set_bus(1'b1, 1'b1);
        set_bus(1'b1, 1'b0);
        set_bus(1'b0, 1'b0);
        send_byte(8'hA0, seen);
        chk("R3 restart recounts command", seen, 8'hA0);
        ack_clock("R3 ack after restarted command");
        send_byte(8'h00, seen);
        ack_clock("R3 ack after address");
    endtask

    task automatic t_stop();
        logic [7:0] seen;
        logic s;
        do_start();
        clk_bit(1'b1, s);
        clk_bit(1'b0, s);
        clk_bit(1'b1, s);
        clk_bit(1'b0, s);
        set_bus(1'b0, 1'b0);
        set_bus(1'b1, 1'b0);
        set_bus(1'b1, 1'b1);
        set_bus(1'b0, 1'b1);
        clk_bit(1'b1, s);
        clk_bit(1'b1, s);
        clk_bit(1'b1, s);
        chk("R4 no early ack", s, 1);
        ack_clock("R4 stop kept bit count");
        send_byte(8'h00, seen);
        ack_clock("R4 ack after address");
    endtask

    task automatic t_coincident();
        logic [7:0] seen;
        logic s;
        do_start();
        for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
        set_bus(1'b1, 1'b0);
        set_bus(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
        clk_bit(1'b1, s);
        chk("R5 coincident change not counted", s, 1);
        ack_clock("R5 ack after eight counted bits");
        send_byte(8'h00, seen);
        ack_clock("R5 ack after address");
    endtask

    task automatic t_reset_mid();
        logic [7:0] seen;
        logic s;
        do_start();
        send_byte(8'hA0, seen);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clk_bit(1'b1, s);
        chk("R11 reset clears pending ack", s, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_idle();
        t_write();
        // R9 R10: read shifts out data loaded from address 0x12
        t_read(rom_val('h12), "R9 read data from 0x12");
        // R8 R10: previous read assembled address 0xFF and reloaded data
        t_read(rom_val('hFF), "R10 read data from 0xFF");
        t_restart();
        t_stop();
        t_coincident();
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule